// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block decides which of five interrupt sources a small 8-bit CPU should service next. The sources are, by index: 0 external line 0, 1 timer 0, 2 external line 1, 3 timer 1 and 4 the serial port (transmit and receive share one request). The block combines the request flags with a per-source enable mask, a global enable and a per-source priority mask. It checks them only at instruction boundaries, which the CPU marks with a one-cycle strobe.

When a request wins, the block sends the CPU a one-cycle take pulse and the fixed vector address of the winning source. In the same cycle it pulses a flag-clear strobe for sources whose flags hardware clears, and a strobe that takes the CPU out of idle mode. It tracks which of the two priority levels are in service, so that only a strictly higher level can interrupt a running handler. The CPU reports each return-from-interrupt, and the block then withholds acceptance for one instruction.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The vector for source index i is 0x0003 + 8*i (0x0003, 0x000B, 0x0013, 0x001B, 0x0023). It appears on `vec_addr` together with `take_irq`, one clock after the boundary strobe at which the source was accepted.
- R2: While `glob_en` is 0, no interrupt is accepted.
- R3: A source counts as pending only when its `src_en` bit and its `req_flag` bit are both 1.
- R4: A source is high priority when its `prio_hi` bit is 1, and low otherwise. A pending high-priority source always beats a pending low one.
- R5: Among pending sources that are eligible at the same priority, the lowest index wins.
- R6: An interrupt is accepted only when its level is strictly above every level in service. Low is accepted only when nothing is in service. High is accepted only when high is not in service.
- R7: Acceptance of sources 0 to 3 pulses that source's `flag_clr` bit for one cycle, together with `take_irq`. Acceptance of source 4 (serial) leaves `flag_clr` all zero, and `flag_clr` is zero whenever `take_irq` is 0.
- R8: At a boundary where `ret_done` is 1, nothing is accepted. The next boundary may accept again.
- R9: `idle_clr` pulses in exactly the cycle of every `take_irq`.
- R10: `act_lvl` bit 1 shows high level in service and bit 0 shows low level in service. Acceptance sets the bit of the accepted level. A return (`ret_done` with `insn_done`) clears bit 1 if it is set, and otherwise clears bit 0.
- R11: Acceptance is evaluated only in cycles where `insn_done` is 1. Pending requests without the strobe produce no `take_irq`.
- R12: After reset, `take_irq`, `idle_clr`, `flag_clr`, `vec_addr` and `act_lvl` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_done | input | 1 | Instruction boundary strobe |
| ret_done | input | 1 | The instruction ending at this boundary was a return-from-interrupt |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enable mask |
| prio_hi | input | 5 | Per-source high-priority mask |
| req_flag | input | 5 | Per-source request flags |
| take_irq | output | 1 | One-cycle pulse: take the interrupt at `vec_addr` |
| vec_addr | output | 16 | Vector of the accepted source |
| flag_clr | output | 5 | One-cycle clear strobe for hardware-cleared request flags |
| idle_clr | output | 1 | One-cycle strobe that clears the idle-mode bit |
| act_lvl | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
On every cycle the assertions check the following:
- no acceptance without a boundary strobe, with the global enable off, or at a return boundary;
- no low-level push while any level is active, and no high-level push while high is active;
- a return pops the high level before the low one;
- the clear strobe is quiet outside acceptances and never has more than one bit set.

Only the bench's scenarios can show that the right source wins. It sweeps every combination of request and priority masks and every enable mask against an arithmetic model. It also walks through nesting sequences: a low handler interrupted by a high one, blocked same-level requests, and the single-instruction hold after a return.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // widest source index the arbiter encodes
   localparam int IDX_W = 3;

   // result of one arbitration
   typedef struct packed {
      logic             valid;
      logic             hi;
      logic [IDX_W-1:0] idx;
   } irq_pick_t;

endpackage

// File: rtl/irqc_ffs.sv
// Lowest-index-first selector: one-hot of the first set bit plus its index.
module irqc_ffs
   import irqc_pkg::*;
#(
   parameter int WIDTH = 5
) (
   input  logic [WIDTH-1:0] vec,
   output logic [WIDTH-1:0] hit,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   logic [WIDTH:0] seen;

   assign seen[0] = 1'b0;

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      assign hit[g]      = vec[g] & ~seen[g];
      assign seen[g + 1] = seen[g] | vec[g];
   end

   assign any = seen[WIDTH];

   always_comb begin
      idx = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (hit[i]) idx = idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/irqc_pick.sv
// Pending qualification and two-level arbitration against the in-service levels.
module irqc_pick
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 5
) (
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] prio_hi,
   input  logic [NUM_SRC-1:0] req_flag,
   input  logic [1:0]         in_service,
   output irq_pick_t          pick,
   output logic [NUM_SRC-1:0] win_oh
);

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] pend_hi;
   logic [NUM_SRC-1:0] pend_lo;
   logic [NUM_SRC-1:0] oh_hi;
   logic [NUM_SRC-1:0] oh_lo;
   logic [IDX_W-1:0]   idx_hi;
   logic [IDX_W-1:0]   idx_lo;
   logic               any_hi;
   logic               any_lo;
   logic               grant_hi;
   logic               grant_lo;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign pend[g]    = glob_en & src_en[g] & req_flag[g];
      assign pend_hi[g] = pend[g] & prio_hi[g];
      assign pend_lo[g] = pend[g] & ~prio_hi[g];
   end

   irqc_ffs #(.WIDTH(NUM_SRC)) u_ffs_hi (
      .vec (pend_hi),
      .hit (oh_hi),
      .idx (idx_hi),
      .any (any_hi)
   );

   irqc_ffs #(.WIDTH(NUM_SRC)) u_ffs_lo (
      .vec (pend_lo),
      .hit (oh_lo),
      .idx (idx_lo),
      .any (any_lo)
   );

   always_comb begin
      grant_hi   = any_hi & ~in_service[1];
      grant_lo   = any_lo & ~any_hi & (in_service == 2'b00);
      pick.valid = grant_hi | grant_lo;
      pick.hi    = grant_hi;
      pick.idx   = grant_hi ? idx_hi : idx_lo;
      if (grant_hi)      win_oh = oh_hi;
      else if (grant_lo) win_oh = oh_lo;
      else               win_oh = '0;
   end

endmodule

// File: rtl/irqc_lvl_stack.sv
// Two-level in-service record: pushes from acceptances, pops from returns.
module irqc_lvl_stack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push_hi,
   input  logic       push_lo,
   input  logic       pop,
   output logic [1:0] act
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 2'b00;
      end else if (pop) begin
         if (act[1]) act[1] <= 1'b0;
         else        act[0] <= 1'b0;
      end else begin
         if (push_hi) act[1] <= 1'b1;
         if (push_lo) act[0] <= 1'b1;
      end
   end

   // R6
   lo_push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_lo |-> act == 2'b00);

   // R6
   hi_push_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_hi |-> !act[1]);

   // R10
   pop_hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && act[1]) |=> (!act[1] && act[0] == $past(act[0])));

   // R10
   pop_lo_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !act[1]) |=> act == 2'b00);

   // R8
   pop_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !(push_hi || push_lo));

endmodule

// File: rtl/vec_irq_ctrl.sv
// Prioritised vectored interrupt controller, top level.
module vec_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int         NUM_SRC     = 5,
   parameter int         ADDR_W      = 16,
   parameter int         VEC_BASE    = 3,
   parameter int         VEC_STRIDE  = 8,
   parameter logic [7:0] HW_CLR_MASK = 8'h0F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_done,
   input  logic               ret_done,
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] prio_hi,
   input  logic [NUM_SRC-1:0] req_flag,
   output logic               take_irq,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic [NUM_SRC-1:0] flag_clr,
   output logic               idle_clr,
   output logic [1:0]         act_lvl
);

   localparam int VEC_LAST  = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);
   localparam int STRIDE_SH = (VEC_STRIDE > 1) ? $clog2(VEC_STRIDE) : 0;

   // elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > (1 << IDX_W)) begin : g_bad_num_src
      $error("vec_irq_ctrl: NUM_SRC must lie in 1..8");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("vec_irq_ctrl: VEC_STRIDE must be positive");
   end
   if (ADDR_W < 2 || ADDR_W > 30 || VEC_LAST >= (1 << ADDR_W)) begin : g_bad_addr
      $error("vec_irq_ctrl: vector table does not fit ADDR_W");
   end

   irq_pick_t          pick;
   logic [NUM_SRC-1:0] win_oh;
   logic [NUM_SRC-1:0] hw_mask;
   logic [ADDR_W-1:0]  vec_next;
   logic               accept;
   logic               ret_pop;
   logic               take_q;
   logic [ADDR_W-1:0]  vec_q;
   logic [NUM_SRC-1:0] clr_q;

   irqc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .glob_en    (glob_en),
      .src_en     (src_en),
      .prio_hi    (prio_hi),
      .req_flag   (req_flag),
      .in_service (act_lvl),
      .pick       (pick),
      .win_oh     (win_oh)
   );

   // a return boundary pops a level and withholds acceptance for that boundary
   assign ret_pop = insn_done & ret_done;
   assign accept  = insn_done & ~ret_done & pick.valid;

   irqc_lvl_stack u_lvl (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_hi (accept & pick.hi),
      .push_lo (accept & ~pick.hi),
      .pop     (ret_pop),
      .act     (act_lvl)
   );

   // sources whose request flag hardware clears on acceptance
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
      assign hw_mask[g] = HW_CLR_MASK[g];
   end

   // vector arithmetic: shift for a power-of-two stride, multiply otherwise
   if ((VEC_STRIDE & (VEC_STRIDE - 1)) == 0) begin : g_vec_shift
      assign vec_next = ADDR_W'(VEC_BASE) + (ADDR_W'(pick.idx) << STRIDE_SH);
   end else begin : g_vec_mul
      assign vec_next = ADDR_W'(VEC_BASE) + ADDR_W'(pick.idx) * ADDR_W'(VEC_STRIDE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
         clr_q  <= '0;
      end else begin
         take_q <= accept;
         clr_q  <= accept ? (win_oh & hw_mask) : '0;
         if (accept) vec_q <= vec_next;
      end
   end

   assign take_irq = take_q;
   assign vec_addr = vec_q;
   assign flag_clr = clr_q;
   assign idle_clr = take_q;

   // R11
   no_strobe_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_done |=> !take_irq);

   // R2
   glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> !take_irq);

   // R8
   ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_done |=> !take_irq);

   // R7
   clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_irq |-> flag_clr == '0);

   // R7
   clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> $onehot0(flag_clr));

   // R1
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (vec_addr >= ADDR_W'(VEC_BASE) && vec_addr <= ADDR_W'(VEC_LAST)));

   // R6
   take_sets_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> act_lvl != 2'b00);

endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_done = 1'b0;
   logic        ret_done = 1'b0;
   logic        glob_en = 1'b0;
   logic [4:0]  src_en = '0;
   logic [4:0]  prio_hi = '0;
   logic [4:0]  req_flag = '0;
   logic        take_irq;
   logic [15:0] vec_addr;
   logic [4:0]  flag_clr;
   logic        idle_clr;
   logic [1:0]  act_lvl;

   int checks = 0;
   int failures = 0;
   logic [1:0] act_m = 2'b00;

   always #2 clk = ~clk;

   vec_irq_ctrl i_vec_irq_ctrl (
      .clk (clk), .rst_n (rst_n), .insn_done (insn_done), .ret_done (ret_done),
      .glob_en (glob_en), .src_en (src_en), .prio_hi (prio_hi), .req_flag (req_flag),
      .take_irq (take_irq), .vec_addr (vec_addr), .flag_clr (flag_clr),
      .idle_clr (idle_clr), .act_lvl (act_lvl)
   );

   task automatic chk(input string tag, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   // one boundary strobe; outputs are sampled at the following falling edge
   task automatic boundary(input logic ret);
      @(negedge clk);
      insn_done = 1'b1;
      ret_done  = ret;
      @(negedge clk);
      insn_done = 1'b0;
      ret_done  = 1'b0;
   endtask

   // arithmetic model of the arbitration rules
   function automatic void predict(input logic [4:0] rq, input logic [4:0] en,
                                   input logic [4:0] pr, input logic g,
                                   input logic [1:0] act, output logic ok,
                                   output int idx, output logic hi);
      logic [4:0] p;
      p   = g ? (rq & en) : 5'd0;
      ok  = 1'b0;
      idx = 0;
      hi  = 1'b0;
      if ((p & pr) != 5'd0) begin
         if (!act[1]) begin
            ok = 1'b1;
            hi = 1'b1;
            for (int i = 4; i >= 0; i--) if (p[i] & pr[i]) idx = i;
         end
      end else if (p != 5'd0 && act == 2'b00) begin
         ok = 1'b1;
         for (int i = 4; i >= 0; i--) if (p[i]) idx = i;
      end
   endfunction

   // boundary without return, compared against the model
   task automatic step_expect(input string tag);
      logic ok;
      logic hi;
      int   idx;
      predict(req_flag, src_en, prio_hi, glob_en, act_m, ok, idx, hi);
      boundary(1'b0);
      chk({tag, " R11 R2 R3 R6 take"}, int'(take_irq), int'(ok));
      chk({tag, " R9 idle_clr"}, int'(idle_clr), int'(ok));
      if (ok) begin
         act_m = act_m | (hi ? 2'b10 : 2'b01);
         chk({tag, " R1 R4 R5 vector"}, int'(vec_addr), 3 + 8 * idx);
         chk({tag, " R7 flag_clr"}, int'(flag_clr), (idx < 4) ? (1 << idx) : 0);
      end else begin
         chk({tag, " R7 flag_clr idle"}, int'(flag_clr), 0);
      end
      chk({tag, " R10 act_lvl"}, int'(act_lvl), int'(act_m));
   endtask

   // return boundary: nothing taken, highest level popped
   task automatic step_return(input string tag);
      boundary(1'b1);
      if (act_m[1]) act_m[1] = 1'b0;
      else          act_m[0] = 1'b0;
      chk({tag, " R8 no take at return"}, int'(take_irq), 0);
      chk({tag, " R10 pop"}, int'(act_lvl), int'(act_m));
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 take", int'(take_irq), 0);
      chk("R12 vec", int'(vec_addr), 0);
      chk("R12 flag_clr", int'(flag_clr), 0);
      chk("R12 idle_clr", int'(idle_clr), 0);
      chk("R12 act", int'(act_lvl), 0);

      // R11: pending requests without a boundary strobe
      glob_en  = 1'b1;
      src_en   = 5'h1F;
      req_flag = 5'h1F;
      repeat (4) begin
         @(negedge clk);
         chk("R11 no strobe", int'(take_irq), 0);
      end

      // R4 R5: all request and priority combinations from idle
      for (int r = 0; r < 32; r++) begin
         for (int p = 0; p < 32; p++) begin
            req_flag = 5'(r);
            prio_hi  = 5'(p);
            step_expect("sweep_rp");
            if (act_m != 2'b00) step_return("sweep_rp");
         end
      end

      // R3: enable mask sweep with all flags raised, low priority
      prio_hi  = 5'h00;
      req_flag = 5'h1F;
      for (int e = 0; e < 32; e++) begin
         src_en = 5'(e);
         step_expect("sweep_en");
         if (act_m != 2'b00) step_return("sweep_en");
      end

      // R2: global enable off
      src_en  = 5'h1F;
      glob_en = 1'b0;
      for (int p = 0; p < 32; p += 7) begin
         prio_hi = 5'(p);
         step_expect("R2 glob_off");
      end
      glob_en = 1'b1;

      // R6 nesting: low handler, blocked low, high preemption, blocked high
      prio_hi  = 5'h00;
      req_flag = 5'b00100;
      step_expect("nest lo accept");
      req_flag = 5'b01100;
      step_expect("R6 lo blocks lo");
      chk("R6 lo blocks lo take", int'(take_irq), 0);
      prio_hi  = 5'b10000;
      req_flag = 5'b11100;
      step_expect("R6 hi preempts lo");
      chk("R7 serial vector", int'(vec_addr), 16'h0023);
      chk("R7 serial no clear", int'(flag_clr), 0);
      step_expect("R6 hi blocks hi");
      chk("R6 hi blocks hi take", int'(take_irq), 0);

      // R8: hold at the return boundary, accept at the next one
      step_return("R8 ret from hi");
      chk("R10 lo still active", int'(act_lvl), 1);
      step_expect("R8 after one insn");
      chk("R8 re-accept take", int'(take_irq), 1);
      step_return("R10 pop hi");
      step_return("R10 pop lo");
      chk("R10 all clear", int'(act_lvl), 0);

      // R7: timer 1 high priority clears its own flag
      prio_hi  = 5'b01000;
      req_flag = 5'b01000;
      step_expect("R7 timer1");
      chk("R7 timer1 clear bit", int'(flag_clr), 8);
      step_return("R7 timer1 ret");

      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule